// File: doc/BRIEF.md
# Handshaking Parallel Port with Wait States

This block joins a fast CPU bus to a slow parallel device. For the input direction it holds one byte and two status flags: one says a byte is waiting, the other records that a byte was lost. The CPU can use the port in two ways. It can poll the status location until the ready flag shows, then read the byte. Or it can read the data location at once and be stalled by the wait line. While stalled, the port asks the device for a byte. The byte passes straight through to the CPU in the cycle the device strobes it.

For the output direction, a write to the data location is held off by the wait line for as long as the device says it cannot take data. The write is handed to the device with a one-cycle strobe in the cycle the device is ready. A single qualified select input stands for the full address decode. The lowest address bit picks the status location (1) or the data location (0).

A bus access lasts as long as its select and strobe stay high. It completes at the first rising clock edge at which the wait line is low.

Top module: `hsk_port`

## Requirements
- R1: After reset the ready and lost-byte flags are clear. The wait line, the device request and the output strobe are all low.
- R2: A status read (select, read, low address bit 1) never waits. It returns bit 0 = byte ready, bit 1 = byte lost, bit 2 = output device can accept data, and zeros above. A device strobe that arrives while no byte is held and no data read is pending sets bit 0 from the next cycle.
- R3: A data read (select, read, low address bit 0) while a byte is held completes without waiting, returns that byte, and clears the ready flag after that cycle.
- R4: A data read while no byte is held raises wait from its first cycle until the cycle the device strobes. In that cycle wait is low and the read returns the device's byte directly. The ready flag stays clear afterwards, so each byte is delivered exactly once and in order.
- R5: A device strobe while a byte is held and not being read in that cycle drops the new byte, keeps the held one, and sets the lost-byte flag. That flag stays set until a status read completes, and the completed status read clears it.
- R6: A device strobe in the same cycle as a completed data read of a held byte returns the held byte, stores the new byte, and leaves the ready flag set without setting the lost-byte flag.
- R7: A data write (select, write, low address bit 0) keeps wait high while the output device is not ready. In the first cycle it is ready, wait is low and the output strobe is high for that one cycle with the written value on the output data.
- R8: A write to the status location, or any access with select low, has no effect: no wait, no request, no output strobe, and the held byte and flags are unchanged.
- R9: The device request is high only during a data read while no byte is held, including the cycle the device strobe completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Qualified address match for this port |
| bus_rd | input | 1 | Read strobe, has priority over write |
| bus_wr | input | 1 | Write strobe |
| bus_a0 | input | 1 | Low address bit: 1 status, 0 data |
| bus_wdata | input | DATA_W | Write data from the CPU |
| bus_rdata | output | DATA_W | Read data to the CPU |
| bus_wait | output | 1 | Stall the current access while high |
| dev_in_stb | input | 1 | Input device offers a byte this cycle |
| dev_in_data | input | DATA_W | Byte from the input device |
| dev_req | output | 1 | Request for a byte toward the input device |
| dev_out_ready | input | 1 | Output device can accept data |
| dev_out_stb | output | 1 | Output byte handed over this cycle |
| dev_out_data | output | DATA_W | Byte to the output device |

## Verification
The properties assume that the CPU holds select, strobe and address stable for the whole of a stalled access. They also assume it never raises read and write together, and that the input device strobes for single cycles. The stimulus changes bus inputs only at falling edges and ends each access only after the cycle in which wait was seen low. In request mode the emulated device strobes only after seeing the request, after a latency swept over several values. Overruns are produced only in the polled tests, where strobes are issued on purpose while a byte is held.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

    // Kind of bus access seen this cycle
    typedef enum logic [2:0] {
        ACC_IDLE    = 3'd0,
        ACC_DATA_RD = 3'd1,
        ACC_STAT_RD = 3'd2,
        ACC_DATA_WR = 3'd3,
        ACC_STAT_WR = 3'd4
    } acc_e;

    // Status word bit positions (software decodes these)
    localparam int STAT_RDY_BIT  = 0;
    localparam int STAT_LOST_BIT = 1;
    localparam int STAT_OUTR_BIT = 2;
    localparam int STAT_USED     = 3;

endpackage

// File: rtl/hsk_decode.sv
module hsk_decode
    import hsk_pkg::*;
(
    input  logic bus_sel,
    input  logic bus_rd,
    input  logic bus_wr,
    input  logic bus_a0,
    output acc_e kind
);

    always_comb begin
        kind = ACC_IDLE;
        if (bus_sel) begin
            if (bus_rd) begin
                kind = bus_a0 ? ACC_STAT_RD : ACC_DATA_RD;
            end else if (bus_wr) begin
                kind = bus_a0 ? ACC_STAT_WR : ACC_DATA_WR;
            end
        end
    end

endmodule

// File: rtl/hsk_in_path.sv
module hsk_in_path
    import hsk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_e              kind,
    input  logic              in_stb,
    input  logic [DATA_W-1:0] in_data,
    output logic              wait_rd,
    output logic              req,
    output logic [DATA_W-1:0] rd_data,
    output logic              rdy,
    output logic              lost
);

    typedef struct packed {
        logic              rdy;
        logic              lost;
        logic [DATA_W-1:0] data;
    } st_t;

    st_t st_d, st_q;

    logic data_rd;
    logic stat_rd;
    logic consume;

    always_comb begin
        data_rd = (kind == ACC_DATA_RD);
        stat_rd = (kind == ACC_STAT_RD);
        consume = data_rd && st_q.rdy;

        wait_rd = data_rd && !st_q.rdy && !in_stb;
        req     = data_rd && !st_q.rdy;
        rd_data = st_q.rdy ? st_q.data : in_data;

        st_d = st_q;
        // completed status read clears the lost flag; a new loss below wins
        if (stat_rd) begin
            st_d.lost = 1'b0;
        end
        if (in_stb) begin
            if (data_rd && !st_q.rdy) begin
                // byte goes straight to the stalled read, nothing stored
                st_d.rdy = 1'b0;
            end else if (st_q.rdy && !consume) begin
                st_d.lost = 1'b1;
            end else begin
                st_d.data = in_data;
                st_d.rdy  = 1'b1;
            end
        end else if (consume) begin
            st_d.rdy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdy  = st_q.rdy;
    assign lost = st_q.lost;

endmodule

// File: rtl/hsk_out_path.sv
module hsk_out_path
    import hsk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  acc_e              kind,
    input  logic [DATA_W-1:0] wdata,
    input  logic              out_ready,
    output logic              wait_wr,
    output logic              out_stb,
    output logic [DATA_W-1:0] out_data
);

    logic data_wr;

    always_comb begin
        data_wr  = (kind == ACC_DATA_WR);
        wait_wr  = data_wr && !out_ready;
        out_stb  = data_wr && out_ready;
        out_data = out_stb ? wdata : '0;
    end

endmodule

// File: rtl/hsk_port.sv
module hsk_port
    import hsk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_a0,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_wait,
    input  logic              dev_in_stb,
    input  logic [DATA_W-1:0] dev_in_data,
    output logic              dev_req,
    input  logic              dev_out_ready,
    output logic              dev_out_stb,
    output logic [DATA_W-1:0] dev_out_data
);

    localparam int STAT_W = (DATA_W < STAT_USED) ? STAT_USED : DATA_W;

    acc_e              kind;
    logic              wait_rd;
    logic              wait_wr;
    logic [DATA_W-1:0] in_rd_data;
    logic              rdy_w;
    logic              lost_w;
    logic [STAT_W-1:0] stat_word;

    hsk_decode u_dec (
        .bus_sel (bus_sel),
        .bus_rd  (bus_rd),
        .bus_wr  (bus_wr),
        .bus_a0  (bus_a0),
        .kind    (kind)
    );

    hsk_in_path #(.DATA_W(DATA_W)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind    (kind),
        .in_stb  (dev_in_stb),
        .in_data (dev_in_data),
        .wait_rd (wait_rd),
        .req     (dev_req),
        .rd_data (in_rd_data),
        .rdy     (rdy_w),
        .lost    (lost_w)
    );

    hsk_out_path #(.DATA_W(DATA_W)) u_out (
        .kind      (kind),
        .wdata     (bus_wdata),
        .out_ready (dev_out_ready),
        .wait_wr   (wait_wr),
        .out_stb   (dev_out_stb),
        .out_data  (dev_out_data)
    );

    always_comb begin
        stat_word                = '0;
        stat_word[STAT_RDY_BIT]  = rdy_w;
        stat_word[STAT_LOST_BIT] = lost_w;
        stat_word[STAT_OUTR_BIT] = dev_out_ready;

        bus_wait = wait_rd | wait_wr;

        unique case (kind)
            ACC_DATA_RD: bus_rdata = in_rd_data;
            ACC_STAT_RD: bus_rdata = stat_word[DATA_W-1:0];
            default:     bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/hsk_port_chk.sv
module hsk_port_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_sel,
    input logic bus_rd,
    input logic bus_wr,
    input logic bus_a0,
    input logic bus_wait,
    input logic dev_in_stb,
    input logic dev_req,
    input logic dev_out_ready,
    input logic dev_out_stb,
    input logic rdy,
    input logic lost
);

    AST_WAIT_ONLY_DATA_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wait |-> (bus_sel && !bus_a0 && (bus_rd || bus_wr))); // R8

    AST_READ_STALLS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_rd && !bus_a0 && !rdy && !dev_in_stb) |-> bus_wait); // R4

    AST_REQ_ONLY_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        dev_req |-> (bus_sel && bus_rd && !bus_a0 && !rdy)); // R9

    AST_READY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && bus_sel && bus_rd && !bus_a0 && !dev_in_stb) |=> !rdy); // R3

    AST_READY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && dev_in_stb && !(bus_sel && bus_rd && !bus_a0)) |=> rdy); // R2

    AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (lost && !(bus_sel && bus_rd && bus_a0)) |=> lost); // R5

    AST_OUT_STB_READY: assert property (@(posedge clk) disable iff (!rst_n)
        dev_out_stb |-> (dev_out_ready && !bus_wait)); // R7

endmodule

bind hsk_port hsk_port_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_a0        (bus_a0),
    .bus_wait      (bus_wait),
    .dev_in_stb    (dev_in_stb),
    .dev_req       (dev_req),
    .dev_out_ready (dev_out_ready),
    .dev_out_stb   (dev_out_stb),
    .rdy           (rdy_w),
    .lost          (lost_w)
);

// File: tb/sim_hsk_port.sv
module sim_hsk_port;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;
    localparam int WD_CYCLES  = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0, bus_a0 = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          bus_wait;
    logic          dev_in_stb;
    logic [DW-1:0] dev_in_data;
    logic          dev_req;
    logic          dev_out_ready = 1'b0;
    logic          dev_out_stb;
    logic [DW-1:0] dev_out_data;

    logic          man_stb = 1'b0, auto_stb = 1'b0;
    logic [DW-1:0] man_data = '0, auto_data = '0;
    logic          auto_en = 1'b0;
    int            dev_lat = 1;
    int            sent = 0;
    int            total = 0, bad = 0;
    bit            done = 1'b0;

    assign dev_in_stb  = man_stb | auto_stb;
    assign dev_in_data = auto_stb ? auto_data : man_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsk_port #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_a0(bus_a0),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wait(bus_wait),
        .dev_in_stb(dev_in_stb), .dev_in_data(dev_in_data), .dev_req(dev_req),
        .dev_out_ready(dev_out_ready), .dev_out_stb(dev_out_stb),
        .dev_out_data(dev_out_data)
    );

    function automatic logic [DW-1:0] seq_val(input int k);
        return DW'((k * 53 + 17) % 256);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // emulated input device: answers a request after dev_lat cycles
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (auto_en && dev_req) begin
                repeat (dev_lat) @(negedge clk);
                auto_stb  = 1'b1;
                auto_data = seq_val(sent);
                sent++;
                @(negedge clk);
                auto_stb = 1'b0;
                #2;
            end
        end
    end

    task automatic bus_idle(input int n);
        repeat (n) begin
            @(negedge clk);
            bus_sel = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_a0 = 1'b0;
        end
    endtask

    task automatic push(input logic [DW-1:0] v);
        @(negedge clk);
        man_stb = 1'b1; man_data = v;
        @(negedge clk);
        man_stb = 1'b0;
    endtask

    task automatic stat_read(input int exp, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_wr = 1'b0; bus_a0 = 1'b1;
        #1;
        chk(bus_wait == 1'b0, req, int'(bus_wait), 0);
        chk(int'(bus_rdata) == exp, req, int'(bus_rdata), exp);
        bus_idle(1);
    endtask

    // data read; returns with the access still driven in its completing cycle
    task automatic data_read(input logic [DW-1:0] exp, input int exp_wait, input string req);
        int  w;
        bit  req_ok;
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_wr = 1'b0; bus_a0 = 1'b0;
        w = 0;
        req_ok = 1'b1;
        forever begin
            #1;
            if (!bus_wait) break;
            if (!dev_req) req_ok = 1'b0;
            w++;
            if (w > 50) break;
            @(negedge clk);
        end
        chk(int'(bus_rdata) == int'(exp), req, int'(bus_rdata), int'(exp));
        chk(w == exp_wait, req, w, exp_wait);
        if (exp_wait > 0) chk(req_ok, "R9", int'(req_ok), 1);
    endtask

    task automatic out_write(input logic [DW-1:0] v, input int lat);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_rd = 1'b0; bus_a0 = 1'b0; bus_wdata = v;
        dev_out_ready = (lat == 0);
        for (int i = 0; i <= lat; i++) begin
            #1;
            if (i < lat) begin
                chk(bus_wait && !dev_out_stb, "R7", {bus_wait, dev_out_stb}, 2'b10);
                @(negedge clk);
                if (i + 1 == lat) dev_out_ready = 1'b1;
            end else begin
                chk(!bus_wait && dev_out_stb, "R7", {bus_wait, dev_out_stb}, 2'b01);
                chk(dev_out_data == v, "R7", int'(dev_out_data), int'(v));
            end
        end
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; dev_out_ready = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=0", WD_CYCLES);
        finish_run();
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(!bus_wait && !dev_req && !dev_out_stb, "R1",
            {bus_wait, dev_req, dev_out_stb}, 0);
        stat_read(0, "R1");

        // R2/R3: polled path
        push(8'hA5);
        stat_read(1, "R2");
        data_read(8'hA5, 0, "R3");
        bus_idle(1);
        stat_read(0, "R3");
        dev_out_ready = 1'b1;
        stat_read(4, "R2");
        dev_out_ready = 1'b0;

        // R5: overrun drops new byte, sticky until status read
        push(8'h11);
        push(8'h22);
        stat_read(3, "R5");
        stat_read(1, "R5");
        data_read(8'h11, 0, "R5");
        bus_idle(1);
        push(8'h33);
        push(8'h44);
        data_read(8'h33, 0, "R5");
        bus_idle(1);
        stat_read(2, "R5");
        stat_read(0, "R5");

        // R6: strobe in the same cycle as a consuming read
        push(8'h5A);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_a0 = 1'b0;
        man_stb = 1'b1; man_data = 8'hC3;
        #1;
        chk(int'(bus_rdata) == 8'h5A && !bus_wait, "R6", int'(bus_rdata), 8'h5A);
        @(negedge clk);
        man_stb = 1'b0; bus_sel = 1'b0; bus_rd = 1'b0;
        stat_read(1, "R6");
        data_read(8'hC3, 0, "R6");
        bus_idle(1);
        stat_read(0, "R6");

        // R8: ignored accesses
        push(8'h77);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_a0 = 1'b1; bus_wdata = 8'hFF;
        #1;
        chk(!bus_wait && !dev_out_stb && !dev_req, "R8",
            {bus_wait, dev_out_stb, dev_req}, 0);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b1; bus_a0 = 1'b0;
        #1;
        chk(!bus_wait && !dev_req, "R8", {bus_wait, dev_req}, 0);
        bus_idle(1);
        stat_read(1, "R8");
        data_read(8'h77, 0, "R8");
        bus_idle(1);
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b1;
        #1;
        chk(!bus_wait && !dev_req, "R9", {bus_wait, dev_req}, 0);
        bus_idle(1);
        stat_read(0, "R8");

        // R4: stalled reads with a swept device latency and idle gap
        auto_en = 1'b1;
        k = 0;
        for (int lat = 1; lat <= 5; lat++) begin
            dev_lat = lat;
            for (int gap = 0; gap <= 2; gap++) begin
                for (int rep = 0; rep < 2; rep++) begin
                    data_read(seq_val(k), lat, "R4");
                    k++;
                    bus_idle(gap);
                end
            end
            bus_idle(1);
        end
        bus_idle(2);
        auto_en = 1'b0;
        chk(sent == k, "R4", sent, k);
        stat_read(0, "R4");

        // R7: output writes held off by the device
        for (int lat = 0; lat <= 4; lat++) begin
            out_write(DW'(8'h30 + lat), lat);
        end
        stat_read(0, "R7");

        finish_run();
    end

endmodule